// File: doc/BRIEF.md
# Multi-format Audio Serial Input Port

This block receives stereo PCM audio arriving on a single serial data line. The data line is framed by a bit clock and a left/right word clock. The block turns each stereo frame into a pair of parallel 24-bit two's-complement samples and raises a one-cycle strobe when a complete pair is ready.

All three serial lines are sampled in one fast system-clock domain. Each line passes through a synchronizer, and edges of the bit clock and the word clock are detected from the synchronized copies. A 2-bit format register selects one of four framing schemes:

- two LSB-justified schemes, 16-bit and 24-bit;
- a 24-bit MSB-justified scheme;
- an I2S-compatible scheme.

The schemes differ in where the sample sits inside each word-clock half and in which word-clock level marks the left channel. Writing the format register also restarts framing, so a new scheme never mixes with a half-received word of the old one.

Top module: `aud_rx_in`

## Requirements
- R1: After a synchronous reset:
  - `fmt_q` reads 2'b11 (I2S).
  - `left_smp` and `right_smp` are zero.
  - `pair_vld` is low.
  - A stream sent in I2S framing with no format write is received correctly.
- R2: The format register changes as follows:
  - `fmt_q` takes `fmt_wdata` one cycle after `fmt_we` is high, and holds its value otherwise.
  - A write discards the word in progress and any captured left sample.
  - `pair_vld` is low in the cycle after a write.
- R3: Serial data is taken only at rising edges of the synchronized bit clock. It arrives MSB first, in two's complement. A word starts at the word-clock transition, or one bit later in I2S.
- R4: Format 2'b00 is 16-bit LSB-justified:
  - Only the last 16 bits before the word-clock transition are kept.
  - They appear on output bits [23:8], and bits [7:0] read zero.
  - Earlier bits in the half are ignored. This holds with 16, 24 or 32 bit clocks per half.
- R5: Format 2'b01 is 24-bit LSB-justified. Only the last 24 bits before the word-clock transition are kept, and earlier bits are ignored.
- R6: Format 2'b10 is MSB-justified. The first 24 bits after the word-clock transition form the sample, and later bits in the half are ignored.
- R7: Format 2'b11 is I2S-compatible:
  - The MSB follows one bit clock after the word-clock transition.
  - Up to 24 bits are kept, and later bits are ignored.
  - With 16 bit clocks per half, the 16 received bits fill [23:8] and [7:0] read zero.
- R8: In formats 2'b00, 2'b01 and 2'b10, word clock high marks the left channel. In format 2'b11, word clock low marks the left channel.
- R9: `pair_vld` behaves as follows:
  - It is a one-cycle pulse. It is raised on the bit-clock rise that ends a right-channel word, one pulse per stereo frame.
  - `right_smp` changes only together with `pair_vld`.
  - `left_smp` changes only one cycle after a bit-clock rise.
  - Both outputs hold the pair until the next update.
- R10: A right word is reported only if a left word completed since the last pair or format write. A right word with no left word before it is dropped, with no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_we | input | 1 | Format register write enable |
| fmt_wdata | input | 2 | New framing format |
| bck_in | input | 1 | Serial bit clock (asynchronous) |
| ws_in | input | 1 | Left/right word clock (asynchronous) |
| sd_in | input | 1 | Serial audio data (asynchronous) |
| fmt_q | output | 2 | Active framing format |
| left_smp | output | SMP_W | Last left-channel sample |
| right_smp | output | SMP_W | Last right-channel sample |
| pair_vld | output | 1 | One-cycle strobe: a new stereo pair is on the outputs |

## Verification
Every format is swept over 16, 24 and 32 bit clocks per half, wherever the width fits. This covers several cases:
- The half is exactly as wide as the sample.
- Extra leading junk bits appear in the LSB-justified formats. This separates "last N bits" from "first N bits".
- Extra trailing junk bits appear in the MSB-justified and I2S formats.

Sample values include the extreme codes 0x800000, 0x7FFFFF, 0xFFFFFF and 0x000001 together with computed mixed patterns. These expose bit-order reversal, lost sign bits, shifted alignment and swapped channels. In the I2S runs the first data bit sits one slot after the word-clock edge, so an off-by-one boundary shows up as a one-bit shift. A separate run starts the stream on a right word right after a format write, to show that an orphan right word produces no pair.

// File: rtl/aud_rx_pkg.sv
`timescale 1ns/1ps
// Shared types for the audio serial input port.
package aud_rx_pkg;

    // Framing scheme selected by the format register. The code values are
    // visible to software and therefore fixed.
    typedef enum logic [1:0] {
        FMT_LSB_SHORT = 2'b00,   // short-word LSB-justified
        FMT_LSB_FULL  = 2'b01,   // full-word LSB-justified
        FMT_MSB_FULL  = 2'b10,   // MSB-justified
        FMT_I2S       = 2'b11    // I2S-compatible, one-bit delay
    } aud_fmt_e;

    // Format that is active after reset.
    localparam aud_fmt_e FMT_AFTER_RST = FMT_I2S;

endpackage

// File: rtl/aud_rx_sync.sv
`timescale 1ns/1ps
// aud_rx_sync: flop chain that brings one asynchronous line into clk.
// Assumes: the line is stable for several clk cycles between changes, so all
// lines passed through chains of equal depth keep their relative order.
module aud_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= d;
            end
        end else begin : g_chain
            // Shift the line through STAGES flops.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/aud_rx_bound.sv
`timescale 1ns/1ps
// aud_rx_bound: finds bit-clock rises and word boundaries.
// Produces:
//   - bit_stb: one cycle for every rise of the synchronized bit clock.
//   - word_start: marks the rise whose data bit is the first bit of a new
//     word. In the justified formats that is the rise on which the word
//     clock is first seen changed. In I2S it is the rise after that.
//   - new_left: the channel of the word that starts.
// Assumes: the word clock never changes together with a bit-clock rise.
module aud_rx_bound (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic is_i2s,
    input  logic bck_s,
    input  logic ws_s,
    output logic bit_stb,
    output logic word_start,
    output logic new_left
);

    logic bck_d;
    logic ws_last;
    logic i2s_pend;
    logic ws_chg;

    assign bit_stb    = bck_s & ~bck_d;
    assign ws_chg     = bit_stb & (ws_s ^ ws_last);
    assign word_start = is_i2s ? (bit_stb & i2s_pend) : ws_chg;
    assign new_left   = is_i2s ? ~ws_s : ws_s;

    // Delayed bit clock for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bck_d <= 1'b0;
        else        bck_d <= bck_s;
    end

    // Word-clock level seen at the previous bit-clock rise.
    always_ff @(posedge clk) begin
        if (!rst_n)       ws_last <= 1'b0;
        else if (bit_stb) ws_last <= ws_s;
    end

    // I2S: remember a word-clock change so the word starts one bit later.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) i2s_pend <= 1'b0;
        else if (bit_stb)      i2s_pend <= ws_s ^ ws_last;
    end

endmodule

// File: rtl/aud_rx_word_cap.sv
`timescale 1ns/1ps
// aud_rx_word_cap: collects the bits of the current word two ways.
//   head: the first W bits, MSB-aligned. Missing bits read zero and bits
//         beyond W are dropped.
//   tail: the last W bits, LSB-aligned, cleared at the start of each word.
// Both hold the word in progress. At a word_start rise they still show the
// word that has just ended, and they reload from the first bit of the new one.
module aud_rx_word_cap #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_stb,
    input  logic         bit_val,
    input  logic         word_start,
    output logic [W-1:0] head,
    output logic [W-1:0] tail
);

    localparam int               CNT_W    = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    logic [CNT_W-1:0] cnt;

    // Bit counter within the word, saturating at W.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (bit_stb && word_start)   cnt <= CNT_W'(1);
        else if (bit_stb && cnt < CNT_FULL) cnt <= cnt + CNT_W'(1);
    end

    // MSB-aligned capture of the leading bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= '0;
        end else if (bit_stb) begin
            if (word_start)          head <= {bit_val, {(W-1){1'b0}}};
            else if (cnt < CNT_FULL) head[(W-1) - int'(cnt)] <= bit_val;
        end
    end

    // LSB-aligned shift register of the trailing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (bit_stb) begin
            if (word_start) tail <= {{(W-1){1'b0}}, bit_val};
            else            tail <= {tail[W-2:0], bit_val};
        end
    end

endmodule

// File: rtl/aud_rx_in.sv
`timescale 1ns/1ps
// aud_rx_in: multi-format audio serial input port (top).
// Oversamples the bit clock, word clock and data in clk, frames the words
// per the selected format, and emits left/right samples with a pair strobe.
// Assumes:
//   - clk is fast enough to see every bit-clock level for at least two cycles.
//   - SHORT_W < SMP_W.
module aud_rx_in
    import aud_rx_pkg::*;
#(
    parameter int SMP_W       = 24,
    parameter int SHORT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fmt_we,
    input  logic [1:0]       fmt_wdata,
    input  logic             bck_in,
    input  logic             ws_in,
    input  logic             sd_in,
    output logic [1:0]       fmt_q,
    output logic [SMP_W-1:0] left_smp,
    output logic [SMP_W-1:0] right_smp,
    output logic             pair_vld
);

    localparam int PAD_W   = SMP_W - SHORT_W;
    localparam int N_LINES = 3;

    aud_fmt_e           fmt_r;
    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lines;
    logic               bit_stb;
    logic               word_start;
    logic               new_left;
    logic [SMP_W-1:0]   head;
    logic [SMP_W-1:0]   tail;
    logic [SMP_W-1:0]   done_word;
    logic               active;
    logic               cur_left;
    logic               got_left;

    assign raw_lines = {sd_in, ws_in, bck_in};
    assign fmt_q     = fmt_r;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_sync
            aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (raw_lines[g]),
                .q    (sync_lines[g])
            );
        end
    endgenerate

    // Format register; a write restarts framing.
    always_ff @(posedge clk) begin
        if (!rst_n)      fmt_r <= FMT_AFTER_RST;
        else if (fmt_we) fmt_r <= aud_fmt_e'(fmt_wdata);
    end

    aud_rx_bound u_bound (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (fmt_we),
        .is_i2s    (fmt_r == FMT_I2S),
        .bck_s     (sync_lines[0]),
        .ws_s      (sync_lines[1]),
        .bit_stb   (bit_stb),
        .word_start(word_start),
        .new_left  (new_left)
    );

    aud_rx_word_cap #(.W(SMP_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .bit_val   (sync_lines[2]),
        .word_start(word_start),
        .head      (head),
        .tail      (tail)
    );

    // Pick the finished word's sample by format.
    always_comb begin
        unique case (fmt_r)
            FMT_LSB_SHORT: done_word = {tail[SHORT_W-1:0], {PAD_W{1'b0}}};
            FMT_LSB_FULL:  done_word = tail;
            default:       done_word = head;
        endcase
    end

    // Channel tracking, sample registers and pair strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            cur_left  <= 1'b0;
            got_left  <= 1'b0;
            pair_vld  <= 1'b0;
            left_smp  <= '0;
            right_smp <= '0;
        end else begin
            pair_vld <= 1'b0;
            if (fmt_we) begin
                active   <= 1'b0;
                got_left <= 1'b0;
            end else if (word_start) begin
                active   <= 1'b1;
                cur_left <= new_left;
                if (active) begin
                    if (cur_left) begin
                        left_smp <= done_word;
                        got_left <= 1'b1;
                    end else if (got_left) begin
                        right_smp <= done_word;
                        pair_vld  <= 1'b1;
                        got_left  <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/aud_rx_chk.sv
`timescale 1ns/1ps
// aud_rx_chk: protocol checks for aud_rx_in, attached by bind.
module aud_rx_chk #(
    parameter int SMP_W = 24,
    parameter int PAD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fmt_we,
    input logic [1:0]       fmt_wdata,
    input logic [1:0]       fmt_q,
    input logic             bit_stb,
    input logic             pair_vld,
    input logic [SMP_W-1:0] left_smp,
    input logic [SMP_W-1:0] right_smp
);

    p_fmt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_we |=> $stable(fmt_q));

    p_fmt_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_we |=> fmt_q == $past(fmt_wdata));

    p_no_pair_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_we |=> !pair_vld);

    p_pair_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |-> $past(bit_stb));

    p_pair_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pair_vld |=> !pair_vld);

    p_right_with_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(right_smp) |-> pair_vld);

    p_left_on_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(left_smp) |-> $past(bit_stb));

    p_short_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && fmt_q == 2'b00) |-> right_smp[PAD_W-1:0] == '0);

endmodule

bind aud_rx_in aud_rx_chk #(.SMP_W(SMP_W), .PAD_W(PAD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt_we   (fmt_we),
    .fmt_wdata(fmt_wdata),
    .fmt_q    (fmt_q),
    .bit_stb  (bit_stb),
    .pair_vld (pair_vld),
    .left_smp (left_smp),
    .right_smp(right_smp)
);

// File: tb/aud_rx_in_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every format over several bit-clock ratios and checks the
// received pairs against values computed from the framing rules.
module aud_rx_in_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_we = 1'b0;
    logic [1:0]  fmt_wdata = 2'b00;
    logic        bck = 1'b0;
    logic        ws = 1'b1;
    logic        sd = 1'b0;
    logic [1:0]  fmt_q;
    logic [23:0] left_smp;
    logic [23:0] right_smp;
    logic        pair_vld;

    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    logic [23:0] cap_l [0:127];
    logic [23:0] cap_r [0:127];
    logic i2s_mode = 1'b0;
    logic hold = 1'b0;

    always #2.5 clk = ~clk;

    aud_rx_in dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fmt_we   (fmt_we),
        .fmt_wdata(fmt_wdata),
        .bck_in   (bck),
        .ws_in    (ws),
        .sd_in    (sd),
        .fmt_q    (fmt_q),
        .left_smp (left_smp),
        .right_smp(right_smp),
        .pair_vld (pair_vld)
    );

    // Record every reported pair.
    always @(negedge clk) begin
        if (rst_n && pair_vld) begin
            cap_l[cap_n % 128] <= left_smp;
            cap_r[cap_n % 128] <= right_smp;
            cap_n <= cap_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bit slot: word clock and data change on the bit-clock fall.
    task automatic slot(input logic w, input logic b);
        @(negedge clk);
        bck = 1'b0;
        ws  = w;
        if (i2s_mode) begin
            sd   = hold;
            hold = b;
        end else begin
            sd = b;
        end
        repeat (3) @(negedge clk);
        bck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    function automatic logic junk(input int k);
        return (k % 3) == 1;
    endfunction

    // Bit k of a half of `half` slots, before the I2S one-slot delay.
    function automatic logic word_bit(input int f, input int half, input logic [23:0] v, input int k);
        int lead;
        if (f == 0) begin
            lead = half - 16;
            return (k < lead) ? junk(k) : v[23 - (k - lead)];
        end else if (f == 1) begin
            lead = half - 24;
            return (k < lead) ? junk(k) : v[23 - (k - lead)];
        end
        return (k < 24) ? v[23 - k] : junk(k);
    endfunction

    function automatic logic [23:0] exp_word(input int f, input int half, input logic [23:0] v);
        if (f == 0) return {v[23:8], 8'h00};
        if (f == 3 && half < 24) return v & (24'hFFFFFF << (24 - half));
        return v;
    endfunction

    function automatic logic [23:0] pick(input int f, input int half, input int j, input bit right);
        if (j == 0) return right ? 24'h7FFFFF : 24'h800000;
        if (j == 1) return right ? 24'h000001 : 24'hFFFFFF;
        return 24'(j * 3824753 + f * 435217 + half * 75391 + (right ? 9370085 : 0));
    endfunction

    function automatic string fmt_tag(input int f);
        case (f)
            0:       return "R3 R4 R8 sample";
            1:       return "R3 R5 R8 sample";
            2:       return "R3 R6 R8 sample";
            default: return "R3 R7 R8 sample";
        endcase
    endfunction

    task automatic send_half(input int f, input int half, input bit left, input logic [23:0] v);
        logic w;
        w = (f == 3) ? !left : left;
        for (int k = 0; k < half; k++) slot(w, word_bit(f, half, v, k));
    endtask

    task automatic write_fmt(input int f);
        @(negedge clk);
        fmt_we    = 1'b1;
        fmt_wdata = 2'(f);
        @(negedge clk);
        fmt_we = 1'b0;
        chk("R2 format load", 24'(fmt_q), 24'(f));
    endtask

    task automatic run_cfg(input int f, input int half, input bit wr);
        logic        idle;
        int          base;
        logic [23:0] lv [4];
        logic [23:0] rv [4];
        idle     = (f == 3);
        i2s_mode = (f == 3);
        hold     = 1'b0;
        repeat (3) slot(idle, 1'b0);
        if (wr) write_fmt(f);
        base = cap_n;
        for (int j = 0; j < 4; j++) begin
            lv[j] = pick(f, half, j, 1'b0);
            rv[j] = pick(f, half, j, 1'b1);
            send_half(f, half, 1'b1, lv[j]);
            send_half(f, half, 1'b0, rv[j]);
        end
        send_half(f, half, 1'b1, 24'h0);
        repeat (3) slot(idle, 1'b0);
        chk("R9 pair count", 24'(cap_n - base), 24'd4);
        for (int j = 0; j < 4; j++) begin
            chk(fmt_tag(f), cap_l[(base + j) % 128], exp_word(f, half, lv[j]));
            chk(fmt_tag(f), cap_r[(base + j) % 128], exp_word(f, half, rv[j]));
        end
    endtask

    // R10: after a restart the stream begins with an orphan right word.
    task automatic run_orphan;
        int base;
        i2s_mode = 1'b0;
        hold     = 1'b0;
        repeat (3) slot(1'b1, 1'b0);
        write_fmt(2);
        base = cap_n;
        send_half(2, 24, 1'b0, 24'h13579B);
        send_half(2, 24, 1'b1, 24'hC0FFEE);
        send_half(2, 24, 1'b0, 24'h2468AC);
        send_half(2, 24, 1'b1, 24'h0);
        repeat (3) slot(1'b1, 1'b0);
        chk("R10 orphan pair count", 24'(cap_n - base), 24'd1);
        chk("R10 left after orphan", cap_l[base % 128], 24'hC0FFEE);
        chk("R10 right after orphan", cap_r[base % 128], 24'h2468AC);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset format", 24'(fmt_q), 24'd3);
        chk("R1 reset left", left_smp, 24'h0);
        chk("R1 reset right", right_smp, 24'h0);
        chk("R1 reset strobe", 24'(pair_vld), 24'd0);
        // R1: default I2S framing used without any format write.
        run_cfg(3, 24, 1'b0);
        for (int f = 0; f < 4; f++) begin
            for (int hi = 0; hi < 3; hi++) begin
                int half;
                half = 16 + 8 * hi;
                if ((f == 1 || f == 2) && half < 24) continue;
                run_cfg(f, half, 1'b1);
            end
        end
        run_orphan();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
        $finish;
    end

endmodule